// File: doc/BRIEF.md
# Dual-Cipher Byte Substitution Unit

This block is a purely combinational byte substitution unit. It produces either the AES S-box or the SM4 S-box of an 8-bit input, and a single mode bit picks which one. The two ciphers define their inverses over different GF(2^8) reduction polynomials. Both inverses are still carried out by one shared multiplicative inverter in the composite field GF((2^4)^2).

The subfield GF(2^4) is reduced by x^4+x^3+x^2+x+1. The extension is reduced by y^2+y+v, with v = 0x2. A composite byte holds its high nibble as the coefficient of y and its low nibble as the constant term. Each cipher gets its own linear stages around the inverter:

- an isomorphism into the composite field;
- an output matrix that folds the inverse isomorphism into that cipher's affine matrix;
- an additive constant.

SM4 also applies its own affine step before the isomorphism. 2:1 multiplexers steer the shared inverter's input and the final output.

A round datapath uses the unit as its nonlinear layer. It instantiates one copy per byte lane and ties the mode bit to the cipher it is running. The unit has no clock and no state.

Top module: `dual_sbox`

## Requirements
- R1: With `mode_sel` = 0, `dout` equals the standard AES S-box value of `din` for every one of the 256 inputs (for example 0x00→0x63, 0x01→0x7C, 0x53→0xED).
- R2: With `mode_sel` = 1, `dout` equals the standard SM4 S-box value of `din` for every one of the 256 inputs. That value is A·inv(A·x+0xD3)+0xD3, with the inverse taken over x^8+x^7+x^6+x^5+x^4+x^2+1, and A defined by y_i = x_i⊕x_(i+1)⊕x_(i+2)⊕x_(i+5)⊕x_(i+7) with indices mod 8 and bit 0 as the LSB (for example 0x00→0xD6, 0x01→0x90, 0x0F→0x05).
- R3: A byte that reaches the inverter as zero comes out as zero without special-case logic, so `din` = 0x00 yields 0x63 in AES mode and 0xD6 in SM4 mode.
- R4: In each mode the mapping from `din` to `dout` is a permutation: the 256 inputs give 256 distinct outputs.
- R5: The output depends only on the present `din` and `mode_sel`. Flipping `mode_sel` while `din` is held gives the other cipher's value in the same evaluation, with no memory of earlier inputs.
- R6: In AES mode no input maps to itself or to its bitwise complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to substitute |
| mode_sel | input | 1 | Cipher choice: 0 = AES, 1 = SM4 |
| dout | output | 8 | Substituted byte |

## Verification
The bench goes after the zero input in both modes. A design that special-cased zero wrongly, or whose inverter did not return zero for zero, would emit something other than 0x63 or 0xD6 there. It also targets the bit-ordering of the mapping matrices. A transposed or bit-reversed matrix still gives a plausible byte for most inputs but breaks the full sweep and the permutation property, which the bench checks by collecting all 256 outputs per mode. Holding `din` while toggling `mode_sel` exposes a multiplexer that steers only one side of the shared inverter. Such a design would return a hybrid of the two ciphers.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int MAT_W  = BYTE_W * BYTE_W;

    typedef enum logic {
        SBOX_AES = 1'b0,
        SBOX_SM4 = 1'b1
    } sbox_mode_e;

    // Composite element: hi is the coefficient of y, lo the constant term.
    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } cf_elem_t;

    // Subfield reduction x^4+x^3+x^2+x+1 (the x^4 term is implicit).
    localparam logic [NIB_W-1:0] SUB_RED = 4'hF;
    // Extension reduction y^2 + y + v.
    localparam logic [NIB_W-1:0] EXT_V   = 4'h2;

    // Matrices are stored as columns, first byte = image of the input MSB.
    localparam logic [MAT_W-1:0] AES_INTO_CF = 64'hE7B6_57B4_646C_A001;
    localparam logic [MAT_W-1:0] AES_OUT_MAT = 64'h5E05_6052_849D_361F;
    localparam logic [MAT_W-1:0] SM4_INTO_CF = 64'h688F_BF84_F0F6_4B01;
    localparam logic [MAT_W-1:0] SM4_OUT_MAT = 64'h0CD9_78F3_44B0_C1CB;
    // SM4 affine matrix A in the same column form.
    localparam logic [MAT_W-1:0] SM4_AFF_MAT = 64'hE5F2_79BC_5E2F_97CB;

    localparam logic [BYTE_W-1:0] AES_ADD = 8'h63;
    localparam logic [BYTE_W-1:0] SM4_ADD = 8'hD3;

    function automatic logic [NIB_W-1:0] gf4_mul(input logic [NIB_W-1:0] a,
                                                 input logic [NIB_W-1:0] b);
        logic [NIB_W-1:0] acc;
        logic [NIB_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[NIB_W-1]) sh = {sh[NIB_W-2:0], 1'b0} ^ SUB_RED;
            else             sh = {sh[NIB_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [NIB_W-1:0] gf4_sq(input logic [NIB_W-1:0] a);
        return gf4_mul(a, a);
    endfunction

    // Schoolbook composite product, used by checks beside the inverter.
    function automatic cf_elem_t cf_mul(input cf_elem_t a, input cf_elem_t b);
        cf_elem_t         r;
        logic [NIB_W-1:0] hh;
        hh   = gf4_mul(a.hi, b.hi);
        r.hi = hh ^ gf4_mul(a.hi, b.lo) ^ gf4_mul(a.lo, b.hi);
        r.lo = gf4_mul(hh, EXT_V) ^ gf4_mul(a.lo, b.lo);
        return r;
    endfunction

endpackage

// File: rtl/sbox_lin_map.sv
module sbox_lin_map
    import sbox_pkg::*;
#(
    parameter int                 W      = BYTE_W,
    parameter logic [W*W-1:0]     COLS   = '0,
    parameter logic [W-1:0]       OFFSET = '0
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    localparam int TOP = W * W - 1;

    logic [W-1:0] masked [W];

    // Column k is the image of input bit W-1-k.
    for (genvar k = 0; k < W; k++) begin : g_col
        assign masked[k] = {W{x[W-1-k]}} & COLS[TOP-W*k -: W];
    end

    always_comb begin
        y = OFFSET;
        for (int k = 0; k < W; k++) y = y ^ masked[k];
    end
endmodule

// File: rtl/sbox_gf4_inv.sv
module sbox_gf4_inv
    import sbox_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    output logic [NIB_W-1:0] a_inv
);
    logic [NIB_W-1:0] p2, p4, p8, p6;

    // a^14 = a^-1 for nonzero a, and zero stays zero.
    always_comb begin
        p2    = gf4_sq(a);
        p4    = gf4_sq(p2);
        p8    = gf4_sq(p4);
        p6    = gf4_mul(p4, p2);
        a_inv = gf4_mul(p8, p6);
    end

    always_comb begin
        if (!$isunknown(a)) begin
            AST_GF4_UNIT: assert (a == '0 || gf4_mul(a, a_inv) == 4'h1) else $error("gf4 inverse wrong"); // R4
            AST_GF4_ZERO: assert (a != '0 || a_inv == '0) else $error("gf4 zero not kept");             // R3
        end
    end
endmodule

// File: rtl/sbox_cf_inv.sv
module sbox_cf_inv
    import sbox_pkg::*;
(
    input  cf_elem_t q,
    output cf_elem_t q_inv
);
    logic [NIB_W-1:0] delta;
    logic [NIB_W-1:0] delta_inv;

    always_comb begin
        delta = gf4_mul(gf4_sq(q.hi), EXT_V) ^ gf4_mul(q.hi, q.lo) ^ gf4_sq(q.lo);
    end

    sbox_gf4_inv u_sub_inv (
        .a     (delta),
        .a_inv (delta_inv)
    );

    always_comb begin
        q_inv.hi = gf4_mul(q.hi, delta_inv);
        q_inv.lo = gf4_mul(q.hi ^ q.lo, delta_inv);
    end

    always_comb begin
        if (!$isunknown(q)) begin
            AST_CF_UNIT: assert (q == '0 || cf_mul(q, q_inv) == cf_elem_t'(8'h01)) else $error("composite inverse wrong"); // R4
            AST_CF_ZERO: assert (q != '0 || q_inv == '0) else $error("composite zero not kept");                          // R3
        end
    end
endmodule

// File: rtl/dual_sbox.sv
module dual_sbox
    import sbox_pkg::*;
(
    input  logic [7:0] din,
    input  logic       mode_sel,
    output logic [7:0] dout
);
    sbox_mode_e       mode;
    logic [BYTE_W-1:0] sm4_pre;
    logic [BYTE_W-1:0] into_cf [2];
    logic [BYTE_W-1:0] leave_cf [2];
    logic [BYTE_W-1:0] stage_in [2];
    cf_elem_t          cf_in;
    cf_elem_t          cf_out;

    assign mode = sbox_mode_e'(mode_sel);

    // SM4 input affine step ahead of its isomorphism.
    sbox_lin_map #(.W(BYTE_W), .COLS(SM4_AFF_MAT), .OFFSET(SM4_ADD)) u_sm4_pre (
        .x (din),
        .y (sm4_pre)
    );

    assign stage_in[SBOX_AES] = din;
    assign stage_in[SBOX_SM4] = sm4_pre;

    // One forward and one return map per cipher.
    for (genvar m = 0; m < 2; m++) begin : g_mode
        localparam logic [MAT_W-1:0]  FWD = (m == 0) ? AES_INTO_CF : SM4_INTO_CF;
        localparam logic [MAT_W-1:0]  RET = (m == 0) ? AES_OUT_MAT : SM4_OUT_MAT;
        localparam logic [BYTE_W-1:0] ADD = (m == 0) ? AES_ADD     : SM4_ADD;

        sbox_lin_map #(.W(BYTE_W), .COLS(FWD), .OFFSET('0)) u_fwd (
            .x (stage_in[m]),
            .y (into_cf[m])
        );

        sbox_lin_map #(.W(BYTE_W), .COLS(RET), .OFFSET(ADD)) u_ret (
            .x (cf_out),
            .y (leave_cf[m])
        );
    end

    assign cf_in = cf_elem_t'((mode == SBOX_SM4) ? into_cf[SBOX_SM4] : into_cf[SBOX_AES]);

    sbox_cf_inv u_shared_inv (
        .q     (cf_in),
        .q_inv (cf_out)
    );

    assign dout = (mode == SBOX_SM4) ? leave_cf[SBOX_SM4] : leave_cf[SBOX_AES];

    always_comb begin
        if (!$isunknown({din, mode_sel})) begin
            AST_AES_ZERO_IN: assert (!(mode == SBOX_AES && din == 8'h00) || dout == 8'h63) else $error("aes zero"); // R3
            AST_SM4_ZERO_IN: assert (!(mode == SBOX_SM4 && din == 8'h00) || dout == 8'hD6) else $error("sm4 zero"); // R3
            AST_AES_NO_FIX: assert (mode != SBOX_AES || (dout != din && dout != ~din)) else $error("aes fixed"); // R6
        end
    end
endmodule

// File: tb/dual_sbox_test.sv
module dual_sbox_test;
    logic       clk = 1'b0;
    logic [7:0] din = 8'h00;
    logic       mode_sel = 1'b0;
    logic [7:0] dout;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    bit         seen [2][256];

    always #10 clk = ~clk;

    dual_sbox uut (
        .din      (din),
        .mode_sel (mode_sel),
        .dout     (dout)
    );

    localparam logic [127:0] AES_HEAD = 128'h637c777bf26b6fc53001672bfed7ab76;
    localparam logic [127:0] SM4_HEAD = 128'hd690e9fecce13db716b614c228fb2c05;

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] red);
        logic [7:0] r;
        logic [7:0] s;
        r = 8'h00;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ s;
            s = s[7] ? ((s << 1) ^ red) : (s << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] finv(input logic [7:0] a, input logic [7:0] red);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (((254 >> i) & 1) == 1) r = fmul(r, p, red);
            p = fmul(p, p, red);
        end
        return r;
    endfunction

    function automatic logic [7:0] aes_ref(input logic [7:0] x);
        logic [7:0] b;
        logic [7:0] o;
        b = finv(x, 8'h1B);
        for (int i = 0; i < 8; i++)
            o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
        return o ^ 8'h63;
    endfunction

    function automatic logic [7:0] sm4_lin(input logic [7:0] x);
        logic [7:0] o;
        for (int i = 0; i < 8; i++)
            o[i] = x[i] ^ x[(i+1)%8] ^ x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
        return o;
    endfunction

    function automatic logic [7:0] sm4_ref(input logic [7:0] x);
        return sm4_lin(finv(sm4_lin(x) ^ 8'hD3, 8'hF5)) ^ 8'hD3;
    endfunction

    function automatic logic [7:0] ref_of(input logic m, input logic [7:0] x);
        return m ? sm4_ref(x) : aes_ref(x);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s din=%02h mode=%0d got=%02h exp=%02h", req, din, mode_sel, got, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [7:0] v);
        @(posedge clk);
        mode_sel = m;
        din      = v;
        @(negedge clk);
    endtask

    initial begin
        // R3: zero input in both modes.
        apply(1'b0, 8'h00);
        check("R3", dout, 8'h63);
        apply(1'b1, 8'h00);
        check("R3", dout, 8'hD6);

        // R1 / R2: full sweep against the computed tables, plus fixed heads.
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 256; v++) begin
                apply(m[0], v[7:0]);
                check(m == 0 ? "R1" : "R2", dout, ref_of(m[0], v[7:0]));
                if (v < 16)
                    check(m == 0 ? "R1" : "R2", dout,
                          m == 0 ? AES_HEAD[127-8*v -: 8] : SM4_HEAD[127-8*v -: 8]);
                if (m == 0 && (dout == v[7:0] || dout == ~v[7:0]))
                    check("R6", dout, ~dout);
                else if (m == 0)
                    n_chk++;
                seen[m][dout] = 1'b1;
            end
        end

        // R4: each mode covers all 256 output values.
        for (int m = 0; m < 2; m++) begin
            int cnt;
            cnt = 0;
            for (int k = 0; k < 256; k++) if (seen[m][k]) cnt++;
            n_chk++;
            if (cnt != 256) begin
                n_fail++;
                $display("FAIL R4 mode=%0d distinct got=%0d exp=256", m, cnt);
            end
        end

        // R5: hold din, flip mode each cycle.
        for (int j = 0; j < 4; j++) begin
            logic [7:0] hold;
            hold = (j == 0) ? 8'h00 : (j == 1) ? 8'h5A : (j == 2) ? 8'hFF : 8'h80;
            for (int t = 0; t < 4; t++) begin
                apply(t[0], hold);
                check("R5", dout, ref_of(t[0], hold));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule